// File: doc/BRIEF.md
# Lockable RAM address and data scrambler

This block sits between a processor's memory request port and a word-organised on-chip RAM so that the stored image does not show the plaintext. Boot firmware loads two secret seeds into write-only registers. One seed is XORed onto the word address, which permutes where each word lives. The other seed, together with the low half of the byte address repeated across the word, is XORed onto every data word on its way into the RAM. The same mask is removed again from the word that comes back, so a write followed by a read at the same address returns the original value. Identical plaintext at two addresses ends up as two different raw words.

After the seeds are loaded, the system raises an application-mode flag. From that moment on the seeds are frozen until the next reset, even if the flag later drops. The request path is purely combinational. Select, byte strobes and ready pass straight through, and the read data is unmasked in the cycle in which the RAM reports ready.

Top module: `ram_cloak`

## Requirements
- R1: After reset both seeds are zero: ram_addr equals cpu_addr[16:2] and ram_wdata equals cpu_wdata XOR {cpu_addr[15:0], cpu_addr[15:0]}.
- R2: A register write (reg_we high) with reg_addr 0x40 while unlocked loads the address seed from reg_wdata[14:0]. The new seed applies from the cycle after the write edge.
- R3: A register write with reg_addr 0x41 while unlocked loads the 32-bit data seed from reg_wdata. The new seed applies from the cycle after the write edge.
- R4: Register writes to any other reg_addr leave both seeds unchanged.
- R5: Once app_mode has been high at any clock edge since reset, the block is locked. Seed writes are ignored, including a write at the same edge as the first high app_mode, and the lock holds after app_mode returns low.
- R6: ram_addr equals cpu_addr[16:2] XOR the address seed.
- R7: ram_wdata equals cpu_wdata XOR the data seed XOR {cpu_addr[15:0], cpu_addr[15:0]}, so equal plaintext at different addresses is stored differently.
- R8: cpu_rdata equals ram_rdata XOR the same mask, so a read at an address returns the word last written there.
- R9: When cpu_req is high, ram_cs is high and ram_we equals cpu_wstrb (bit i enables byte i, bits 8i+7:8i). When cpu_req is low, ram_cs and ram_we are zero. A partial write followed by a full read returns the merged word.
- R10: cpu_ready equals ram_ready in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Control register word offset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| app_mode | input | 1 | Application mode flag; its first high edge locks the seeds |
| cpu_req | input | 1 | CPU selects the RAM |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | CPU write word |
| cpu_wstrb | input | 4 | CPU byte write enables |
| cpu_rdata | output | 32 | Unmasked read word to the CPU |
| cpu_ready | output | 1 | Access complete, passed from the RAM |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 4 | RAM byte write enables |
| ram_addr | output | 15 | Permuted RAM word address |
| ram_wdata | output | 32 | Masked word written to the RAM |
| ram_rdata | input | 32 | Raw word read from the RAM |
| ram_ready | input | 1 | RAM access complete |

## Verification
Two conditions are hard to reach from the ports. The first is a seed write arriving at the same edge as the first high app_mode. The second is a write after app_mode has dropped low again, which must still be refused. The stimulus drives both cases. A reference model then checks, on every cycle, the RAM address and write data against the seeds it believes are live, so a leaked seed update shows up at once as a wrong physical address. Earlier stored words must also still read back correctly after the refused writes, and a byte-strobed write into a masked word must merge cleanly on read.

// File: rtl/ram_cloak_pkg.sv
package ram_cloak_pkg;
   localparam int unsigned DEF_REG_AW    = 8;
   localparam int unsigned DEF_DW        = 32;
   localparam int unsigned DEF_CPU_AW    = 32;
   localparam int unsigned DEF_RAM_AW    = 15;
   localparam int unsigned DEF_ASEED_OFS = 8'h40;
   localparam int unsigned DEF_DSEED_OFS = 8'h41;
endpackage

// File: rtl/cloak_seed_regs.sv
module cloak_seed_regs #(
   parameter int unsigned REG_AW    = 8,
   parameter int unsigned DW        = 32,
   parameter int unsigned ASEED_W   = 15,
   parameter int unsigned ASEED_OFS = 8'h40,
   parameter int unsigned DSEED_OFS = 8'h41
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic               reg_we,
   input  logic [DW-1:0]      reg_wdata,
   input  logic               app_mode,
   output logic [ASEED_W-1:0] a_seed,
   output logic [DW-1:0]      d_seed
);
   localparam logic [REG_AW-1:0] A_OFS = REG_AW'(ASEED_OFS);
   localparam logic [REG_AW-1:0] D_OFS = REG_AW'(DSEED_OFS);

   if (ASEED_W > DW) begin : g_bad_seed_w
      $error("address seed wider than register data");
   end
   if (A_OFS == D_OFS) begin : g_bad_ofs
      $error("seed offsets must differ");
   end

   logic lock_q;
   logic lock_now;
   logic wr_ok;

   assign lock_now = lock_q | app_mode;
   assign wr_ok    = reg_we & ~lock_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         a_seed <= '0;
         d_seed <= '0;
      end else begin
         lock_q <= lock_now;
         if (wr_ok && reg_addr == A_OFS) a_seed <= reg_wdata[ASEED_W-1:0];
         if (wr_ok && reg_addr == D_OFS) d_seed <= reg_wdata;
      end
   end

   // R5
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R5
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q || app_mode) |=> ($stable(a_seed) && $stable(d_seed)));

   // R4
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we || (reg_addr != A_OFS && reg_addr != D_OFS))
      |=> ($stable(a_seed) && $stable(d_seed)));
endmodule

// File: rtl/cloak_addr_perm.sv
module cloak_addr_perm #(
   parameter int unsigned CPU_AW = 32,
   parameter int unsigned RAM_AW = 15,
   parameter int unsigned DW     = 32
) (
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [RAM_AW-1:0] a_seed,
   output logic [RAM_AW-1:0] ram_addr
);
   localparam int unsigned WORD_LSB = $clog2(DW / 8);
   localparam int unsigned WORD_MSB = WORD_LSB + RAM_AW - 1;

   if (WORD_MSB >= CPU_AW) begin : g_bad_aw
      $error("RAM word address exceeds CPU address width");
   end

   assign ram_addr = cpu_addr[WORD_MSB:WORD_LSB] ^ a_seed;
endmodule

// File: rtl/cloak_data_mask.sv
module cloak_data_mask #(
   parameter int unsigned CPU_AW = 32,
   parameter int unsigned DW     = 32
) (
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DW-1:0]     d_seed,
   output logic [DW-1:0]     mask
);
   localparam int unsigned MIX_W = DW / 2;
   localparam int unsigned REPS  = DW / MIX_W;

   if (DW % 2 != 0) begin : g_bad_dw
      $error("data width must be even");
   end
   if (MIX_W > CPU_AW) begin : g_bad_mix
      $error("address mix wider than CPU address");
   end

   logic [DW-1:0] addr_fill;

   for (genvar r = 0; r < REPS; r++) begin : g_fill
      assign addr_fill[r*MIX_W +: MIX_W] = cpu_addr[MIX_W-1:0];
   end

   assign mask = d_seed ^ addr_fill;
endmodule

// File: rtl/ram_cloak.sv
module ram_cloak
   import ram_cloak_pkg::*;
#(
   parameter int unsigned REG_AW    = DEF_REG_AW,
   parameter int unsigned DW        = DEF_DW,
   parameter int unsigned CPU_AW    = DEF_CPU_AW,
   parameter int unsigned RAM_AW    = DEF_RAM_AW,
   parameter int unsigned ASEED_OFS = DEF_ASEED_OFS,
   parameter int unsigned DSEED_OFS = DEF_DSEED_OFS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DW-1:0]     reg_wdata,
   input  logic              app_mode,
   input  logic              cpu_req,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DW-1:0]     cpu_wdata,
   input  logic [DW/8-1:0]   cpu_wstrb,
   output logic [DW-1:0]     cpu_rdata,
   output logic              cpu_ready,
   output logic              ram_cs,
   output logic [DW/8-1:0]   ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [DW-1:0]     ram_wdata,
   input  logic [DW-1:0]     ram_rdata,
   input  logic              ram_ready
);
   localparam int unsigned NBYTES = DW / 8;

   if (DW % 8 != 0) begin : g_bad_bytes
      $error("data width must be whole bytes");
   end

   logic [RAM_AW-1:0] a_seed;
   logic [DW-1:0]     d_seed;
   logic [DW-1:0]     mask;

   cloak_seed_regs #(
      .REG_AW(REG_AW), .DW(DW), .ASEED_W(RAM_AW),
      .ASEED_OFS(ASEED_OFS), .DSEED_OFS(DSEED_OFS)
   ) u_seeds (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .app_mode(app_mode),
      .a_seed(a_seed), .d_seed(d_seed)
   );

   cloak_addr_perm #(.CPU_AW(CPU_AW), .RAM_AW(RAM_AW), .DW(DW)) u_perm (
      .cpu_addr(cpu_addr), .a_seed(a_seed), .ram_addr(ram_addr)
   );

   cloak_data_mask #(.CPU_AW(CPU_AW), .DW(DW)) u_mask (
      .cpu_addr(cpu_addr), .d_seed(d_seed), .mask(mask)
   );

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign ram_we[b] = cpu_req & cpu_wstrb[b];
   end

   assign ram_cs    = cpu_req;
   assign ram_wdata = cpu_wdata ^ mask;
   assign cpu_rdata = ram_rdata ^ mask;
   assign cpu_ready = ram_ready;

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |-> (!ram_cs && ram_we == '0));

   // R8
   roundtrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ram_wdata ^ cpu_rdata) == (cpu_wdata ^ ram_rdata)));
endmodule

// File: tb/ram_cloak_tb.sv
`timescale 1ns/1ps
module ram_cloak_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        app_mode = 1'b0;
   logic        cpu_req = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [3:0]  cpu_wstrb = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_ready;
   logic        ram_cs;
   logic [3:0]  ram_we;
   logic [14:0] ram_addr;
   logic [31:0] ram_wdata;
   logic [31:0] ram_rdata = '0;
   logic        ram_ready = 1'b0;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ram_cloak u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .app_mode(app_mode), .cpu_req(cpu_req),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wstrb(cpu_wstrb),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .ram_cs(ram_cs),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .ram_ready(ram_ready)
   );

   // RAM model
   logic [31:0] mem [int];
   always @(posedge clk) begin
      logic [31:0] w;
      ram_ready <= 1'b0;
      if (ram_cs) begin
         w = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 32'h0;
         ram_rdata <= w;
         ram_ready <= 1'b1;
         for (int b = 0; b < 4; b++)
            if (ram_we[b]) w[8*b +: 8] = ram_wdata[8*b +: 8];
         mem[int'(ram_addr)] = w;
      end
   end

   // Reference seed state
   logic [14:0] m_aseed = '0;
   logic [31:0] m_dseed = '0;
   bit          m_locked = 1'b0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_aseed <= '0; m_dseed <= '0; m_locked <= 1'b0;
      end else begin
         if (app_mode) m_locked <= 1'b1;
         if (reg_we && !m_locked && !app_mode) begin
            if (reg_addr == 8'h40) m_aseed <= reg_wdata[14:0];
            if (reg_addr == 8'h41) m_dseed <= reg_wdata;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_mask(input logic [31:0] a);
      return m_dseed ^ {a[15:0], a[15:0]};
   endfunction

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R6 ram_addr", {17'h0, ram_addr}, {17'h0, cpu_addr[16:2] ^ m_aseed});
         check("R7 ram_wdata", ram_wdata, cpu_wdata ^ m_mask(cpu_addr));
         check("R8 cpu_rdata", cpu_rdata, ram_rdata ^ m_mask(cpu_addr));
         check("R9 ram_cs", {31'h0, ram_cs}, {31'h0, cpu_req});
         check("R9 ram_we", {28'h0, ram_we}, {28'h0, cpu_req ? cpu_wstrb : 4'h0});
         check("R10 cpu_ready", {31'h0, cpu_ready}, {31'h0, ram_ready});
      end
   end

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d, input bit am);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1; app_mode = am;
      @(negedge clk);
      reg_we = 1'b0; app_mode = 1'b0;
   endtask

   task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      cpu_req = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_wstrb = s;
      @(negedge clk);
      cpu_req = 1'b0; cpu_wstrb = '0;
   endtask

   task automatic cpu_read(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      cpu_req = 1'b1; cpu_addr = a; cpu_wdata = '0; cpu_wstrb = '0;
      @(negedge clk);
      d = cpu_rdata;
      cpu_req = 1'b0;
   endtask

   function automatic logic [31:0] pat(input int i);
      return (i * 32'h9E3779B9) ^ 32'h0000A5A5;
   endfunction
   function automatic logic [31:0] adr(input int i);
      return 32'h1000 + i * 32'h84;
   endfunction

   initial begin
      #(8ns * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: zero seeds after reset
      @(negedge clk);
      cpu_addr = 32'h0001_2344; cpu_wdata = 32'hCAFE_0001;
      #1;
      check("R1 addr", {17'h0, ram_addr}, {17'h0, 15'h48D1});
      check("R1 wdata", ram_wdata, 32'hCAFE_0001 ^ 32'h2344_2344);
      cpu_write(32'h100, 32'h1234_5678, 4'hF);
      check("R1 raw", mem[32'h40], 32'h1234_5678 ^ 32'h0100_0100);

      // R2/R3 seed loads, R4 other offset
      reg_write(8'h40, 32'h1337_1337, 1'b0);
      reg_write(8'h41, 32'h4711_4711, 1'b0);
      reg_write(8'h42, 32'hFFFF_FFFF, 1'b0);
      reg_write(8'h00, 32'hFFFF_FFFF, 1'b0);
      @(negedge clk);
      cpu_addr = 32'h0; cpu_wdata = 32'h0;
      #1;
      check("R2 aseed", {17'h0, ram_addr}, {17'h0, 15'h1337});
      check("R3 dseed", ram_wdata, 32'h4711_4711);

      for (int i = 0; i < 40; i++) cpu_write(adr(i), pat(i), 4'hF);
      for (int i = 0; i < 40; i++) begin
         logic [31:0] a;
         cpu_read(adr(i), rd);
         check("R8 readback", rd, pat(i));
         a = adr(i);
         check("R6 R7 raw", mem[int'(a[16:2] ^ 15'h1337)],
               pat(i) ^ 32'h4711_4711 ^ {a[15:0], a[15:0]});
         if (mem[int'(a[16:2] ^ 15'h1337)] === pat(i)) check("R7 hidden", 32'h1, 32'h0);
      end
      // R7 equal plaintext, different stored
      cpu_write(32'h2000, 32'h5555_AAAA, 4'hF);
      cpu_write(32'h2004, 32'h5555_AAAA, 4'hF);
      check("R7 distinct", {31'h0, mem[int'(15'h0800 ^ 15'h1337)] !== mem[int'(15'h0801 ^ 15'h1337)]}, 32'h1);

      // R9 partial write
      cpu_write(32'h3000, 32'h1122_3344, 4'hF);
      cpu_write(32'h3000, 32'hAABB_CCDD, 4'b0100);
      cpu_read(32'h3000, rd);
      check("R9 merge", rd, 32'h11BB_3344);

      // R5 lock: write at same edge as app_mode, then after it drops
      reg_write(8'h40, 32'h0000_7FFF, 1'b1);
      reg_write(8'h40, 32'hDEAD_BEEF, 1'b0);
      reg_write(8'h41, 32'hF00F_F00F, 1'b0);
      @(negedge clk);
      cpu_addr = 32'h0; cpu_wdata = 32'h0;
      #1;
      check("R5 aseed kept", {17'h0, ram_addr}, {17'h0, 15'h1337});
      check("R5 dseed kept", ram_wdata, 32'h4711_4711);
      for (int i = 0; i < 40; i += 7) begin
         cpu_read(adr(i), rd);
         check("R5 readback", rd, pat(i));
      end

      // R10 ready low when idle
      @(negedge clk);
      check("R10 idle", {31'h0, cpu_ready}, 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule